// File: doc/BRIEF.md
# Threshold-Driven Data FIFO

This block is a 32-word by 16-bit circular buffer placed between a processor data port and a card-side transfer engine. In the card-to-host (receive) direction the engine pushes and the processor pops. In the host-to-card (transmit) direction the processor pushes and the engine pops. The block reports the number of words it holds. It asks for service when that count crosses a programmable threshold.

A 16-bit configuration register holds an almost-full level, an almost-empty level and one DMA enable for each direction. Only the threshold that belongs to the current direction is evaluated. When that threshold is crossed, the enable bit for the direction decides the output: a DMA request line is raised, or a level-style status flag is set instead. All service outputs are registered. A write to the configuration register takes effect on the current occupancy, with no push or pop needed.

Top module: `svc_fifo`

## Requirements
- R1: After reset the level is 0, `cfgRdData` reads 16'h1F00, and all four service outputs and `popUnderrun` are low.
- R2: Words leave in the order they were accepted. `popData` shows the oldest stored word whenever `level` is non-zero. Storage wraps circularly across its 32 slots, and `level` counts the stored words, one cycle after each accepted push or pop.
- R3: Configuration layout: bit 15 is the receive-DMA enable, bits 12:8 are the almost-full level, bit 7 is the transmit-DMA enable and bits 4:0 are the almost-empty level. All other bits read 0. `cfgRdData` shows a write one cycle after it.
- R4: `level` never exceeds 32. A push while 32 words are held is dropped and leaves the contents unchanged.
- R5: A pop while the buffer is empty changes no pointer and raises `popUnderrun` for exactly one cycle, one cycle later. A push in the same cycle is still accepted.
- R6: A push and a pop in the same cycle, with the buffer neither empty nor full, leave `level` unchanged and perform both.
- R7: With `dirRx`=1, a level above the almost-full level raises `rxDmaReq` if receive DMA is enabled and raises `almostFullFlag` otherwise. If the level is not above it, both are low. The outputs follow `level` with one cycle of delay.
- R8: With `dirRx`=0, a level below the almost-empty level raises `txDmaReq` if transmit DMA is enabled and raises `almostEmptyFlag` otherwise. If the level is not below it, both are low. The outputs follow `level` with one cycle of delay.
- R9: Only the current direction's threshold is evaluated. The other direction's request and flag stay low, whatever that direction's level and enable bit hold.
- R10: When `xferActive` is low and the buffer is empty, all four service outputs are low one cycle later.
- R11: A configuration write changes the service outputs, based on the unchanged current level, two cycles after the write is presented: one cycle to load the register and one to register the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pushEn | input | 1 | Push `pushData` this cycle |
| pushData | input | 16 | Word to store |
| popEn | input | 1 | Remove the oldest word this cycle |
| popData | output | 16 | Oldest stored word |
| popUnderrun | output | 1 | One-cycle pulse after a pop attempted on an empty buffer |
| cfgWrEn | input | 1 | Load the configuration register |
| cfgWrData | input | 16 | New configuration value |
| cfgRdData | output | 16 | Current configuration value |
| xferActive | input | 1 | A transfer is in progress |
| dirRx | input | 1 | 1 = card-to-host, 0 = host-to-card |
| level | output | 6 | Number of words held (0 to 32) |
| rxDmaReq | output | 1 | Receive DMA request |
| almostFullFlag | output | 1 | Almost-full status flag |
| txDmaReq | output | 1 | Transmit DMA request |
| almostEmptyFlag | output | 1 | Almost-empty status flag |

## Verification
`level`, `cfgRdData` and `popUnderrun` are due one clock edge after the stimulus edge. The four service outputs are due one edge after `level` or the configuration register changes, so two edges after a push, pop or configuration write. The bench drives and samples on falling edges. It checks `level` at the first falling edge after a push or pop, and checks the service outputs only after one more full cycle. The R11 check also samples the intermediate edge, to confirm that the outputs have not yet moved.

// File: rtl/svc_fifo_pkg.sv
package svc_fifo_pkg;

  // Strobes from the control block to the datapath
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;

  // Registered service outputs
  typedef struct packed {
    logic rxReq;
    logic stsFull;
    logic txReq;
    logic stsEmpty;
  } svcOut_t;

endpackage

// File: rtl/svc_fifo_dp.sv
module svc_fifo_dp
  import svc_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strb,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] popData,
  output logic [CNT_W-1:0]  count
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  head;
  logic [PTR_W-1:0]  wrSlot;

  // DEPTH is a power of two, so the slot index wraps naturally
  assign wrSlot  = head + count[PTR_W-1:0];
  assign popData = mem[head];

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrSlot] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      head  <= '0;
      count <= '0;
    end else begin
      if (strb.pop) head <= head + PTR_W'(1);
      count <= count + CNT_W'(strb.push) - CNT_W'(strb.pop);
    end
  end

  // R4: occupancy bounded by the storage depth
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R4: a full buffer without a pop stays full
  a_r4_full_hold: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_W'(DEPTH) && !strb.pop) |=> count == CNT_W'(DEPTH));

  // R6: simultaneous push and pop keep occupancy
  a_r6_net_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && strb.pop) |=> $stable(count));

endmodule

// File: rtl/svc_fifo_ctrl.sv
module svc_fifo_ctrl
  import svc_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CFG_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int RX_EN_BIT = 15,
  localparam int AF_LSB    = 8,
  localparam int TX_EN_BIT = 7,
  localparam int AE_LSB    = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic             popEn,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             xferActive,
  input  logic             dirRx,
  input  logic [CNT_W-1:0] count,
  output fifoStrobe_t      strb,
  output svcOut_t          svc,
  output logic [CFG_W-1:0] cfgRdData,
  output logic             underrun
);

  logic             rxDmaEn;
  logic             txDmaEn;
  logic [PTR_W-1:0] afLvl;
  logic [PTR_W-1:0] aeLvl;
  logic             isEmpty;
  logic             isFull;
  logic             overAf;
  logic             underAe;
  svcOut_t          svcNext;

  assign isEmpty = (count == '0);
  assign isFull  = (count == CNT_W'(DEPTH));
  assign overAf  = count > {1'b0, afLvl};
  assign underAe = count < {1'b0, aeLvl};

  assign strb.push = pushEn && !isFull;
  assign strb.pop  = popEn && !isEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxDmaEn <= 1'b0;
      txDmaEn <= 1'b0;
      afLvl   <= PTR_W'(DEPTH - 1);
      aeLvl   <= '0;
    end else if (cfgWrEn) begin
      rxDmaEn <= cfgWrData[RX_EN_BIT];
      txDmaEn <= cfgWrData[TX_EN_BIT];
      afLvl   <= cfgWrData[AF_LSB +: PTR_W];
      aeLvl   <= cfgWrData[AE_LSB +: PTR_W];
    end
  end

  always_comb begin
    cfgRdData = '0;
    cfgRdData[RX_EN_BIT] = rxDmaEn;
    cfgRdData[TX_EN_BIT] = txDmaEn;
    cfgRdData[AF_LSB +: PTR_W] = afLvl;
    cfgRdData[AE_LSB +: PTR_W] = aeLvl;
  end

  always_comb begin
    svcNext = '0;
    if (xferActive || !isEmpty) begin
      if (dirRx && overAf) begin
        if (rxDmaEn) svcNext.rxReq   = 1'b1;
        else         svcNext.stsFull = 1'b1;
      end
      if (!dirRx && underAe) begin
        if (txDmaEn) svcNext.txReq    = 1'b1;
        else         svcNext.stsEmpty = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      svc      <= '0;
      underrun <= 1'b0;
    end else begin
      svc      <= svcNext;
      underrun <= popEn && isEmpty;
    end
  end

  // R5: empty pop reports an underrun on the next cycle
  a_r5_underrun: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && count == '0) |=> underrun);

  // R9: the inactive direction's outputs stay low
  a_r9_rx_side_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !dirRx |=> (!svc.rxReq && !svc.stsFull));
  a_r9_tx_side_quiet: assert property (@(posedge clk) disable iff (!rstN)
    dirRx |=> (!svc.txReq && !svc.stsEmpty));

  // R10: idle and empty clears every service output
  a_r10_idle_clear: assert property (@(posedge clk) disable iff (!rstN)
    (!xferActive && count == '0) |=> (svc == '0));

  // R7: receive request and flag never together
  a_r7_rx_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(svc.rxReq && svc.stsFull));

  // R8: transmit request and flag never together
  a_r8_tx_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(svc.txReq && svc.stsEmpty));

endmodule

// File: rtl/svc_fifo.sv
module svc_fifo
  import svc_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int CFG_W  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushEn,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popEn,
  output logic [DATA_W-1:0] popData,
  output logic              popUnderrun,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  output logic [CFG_W-1:0]  cfgRdData,
  input  logic              xferActive,
  input  logic              dirRx,
  output logic [CNT_W-1:0]  level,
  output logic              rxDmaReq,
  output logic              almostFullFlag,
  output logic              txDmaReq,
  output logic              almostEmptyFlag
);

  fifoStrobe_t strb;
  svcOut_t     svc;

  svc_fifo_ctrl #(.DEPTH(DEPTH), .CFG_W(CFG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .popEn(popEn),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .xferActive(xferActive),
    .dirRx(dirRx), .count(level), .strb(strb), .svc(svc),
    .cfgRdData(cfgRdData), .underrun(popUnderrun)
  );

  svc_fifo_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .pushData(pushData),
    .popData(popData), .count(level)
  );

  assign rxDmaReq        = svc.rxReq;
  assign almostFullFlag  = svc.stsFull;
  assign txDmaReq        = svc.txReq;
  assign almostEmptyFlag = svc.stsEmpty;

endmodule

// File: tb/tb_svc_fifo.sv
`timescale 1ns/1ps
module tb_svc_fifo;

  logic        clk = 1'b0;
  logic        rstN;
  logic        pushEn, popEn, cfgWrEn, xferActive, dirRx;
  logic [15:0] pushData, cfgWrData;
  logic [15:0] popData, cfgRdData;
  logic        popUnderrun;
  logic [5:0]  level;
  logic        rxDmaReq, almostFullFlag, txDmaReq, almostEmptyFlag;

  int checks = 0;
  int errors = 0;
  logic [15:0] model[$];

  always #4 clk = ~clk;

  svc_fifo dut (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .pushData(pushData),
    .popEn(popEn), .popData(popData), .popUnderrun(popUnderrun),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .xferActive(xferActive), .dirRx(dirRx), .level(level),
    .rxDmaReq(rxDmaReq), .almostFullFlag(almostFullFlag),
    .txDmaReq(txDmaReq), .almostEmptyFlag(almostEmptyFlag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pushW(input logic [15:0] d);
    pushData = d;
    pushEn = 1'b1;
    step();
    pushEn = 1'b0;
    if (model.size() < 32) model.push_back(d);
  endtask

  task automatic popW();
    popEn = 1'b1;
    step();
    popEn = 1'b0;
    if (model.size() > 0) void'(model.pop_front());
  endtask

  task automatic wrCfg(input logic [15:0] v);
    cfgWrData = v;
    cfgWrEn = 1'b1;
    step();
    cfgWrEn = 1'b0;
  endtask

  // {rxDmaReq, almostFullFlag, txDmaReq, almostEmptyFlag}
  function automatic logic [3:0] expSvc(int lvl, bit rx, bit dma, int thr, bit act);
    logic [3:0] e = 4'b0000;
    if (!act && lvl == 0) return e;
    if (rx && lvl > thr) e = dma ? 4'b1000 : 4'b0100;
    if (!rx && lvl < thr) e = dma ? 4'b0010 : 4'b0001;
    return e;
  endfunction

  function automatic logic [3:0] svcNow();
    return {rxDmaReq, almostFullFlag, txDmaReq, almostEmptyFlag};
  endfunction

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; pushEn = 1'b0; popEn = 1'b0; cfgWrEn = 1'b0;
    xferActive = 1'b0; dirRx = 1'b0; pushData = '0; cfgWrData = '0;
    repeat (3) step();
    rstN = 1'b1;
    step();

    // R1 reset state
    chk("R1 level", level, 0);
    chk("R1 cfg", cfgRdData, 16'h1F00);
    chk("R1 svc", svcNow(), 4'b0000);
    chk("R1 underrun", popUnderrun, 0);

    // R3 field layout, reserved bits read zero
    wrCfg(16'hFFFF);
    chk("R3 cfg all ones", cfgRdData, 16'h9F9F);
    wrCfg(16'h0A85);
    chk("R3 cfg pattern", cfgRdData, 16'h0A85);
    wrCfg(16'h1F00);

    // move head off zero so the sweep wraps the storage (R2)
    for (int i = 0; i < 3; i++) begin pushW(16'h0100 + 16'(i)); popW(); end
    step();

    // sweep: direction x dma enable x threshold x every level
    xferActive = 1'b1;
    for (int r = 0; r < 2; r++) begin
      for (int d = 0; d < 2; d++) begin
        for (int ti = 0; ti < 4; ti++) begin
          int thr;
          logic [15:0] cfg;
          string tag;
          thr = (ti == 0) ? 0 : (ti == 1) ? 5 : (ti == 2) ? 16 : 31;
          tag = r ? "R7 R9 rx" : "R8 R9 tx";
          dirRx = r[0];
          // opposite direction's fields set so that it would fire if evaluated
          if (r == 1) cfg = {d[0], 2'b00, 5'(thr), d[0], 2'b00, 5'd31};
          else        cfg = {d[0], 2'b00, 5'd0, d[0], 2'b00, 5'(thr)};
          wrCfg(cfg);
          step();
          chk("R2 level empty", level, 0);
          chk(tag, svcNow(), expSvc(0, r[0], d[0], thr, 1'b1));
          for (int k = 1; k <= 32; k++) begin
            pushW(16'(r * 4096 + d * 2048 + ti * 256 + k));
            chk("R2 level up", level, k);
            step();
            chk(tag, svcNow(), expSvc(k, r[0], d[0], thr, 1'b1));
          end
          for (int k = 31; k >= 0; k--) begin
            chk("R2 order", popData, model[0]);
            popW();
            chk("R2 level down", level, k);
            step();
            chk(tag, svcNow(), expSvc(k, r[0], d[0], thr, 1'b1));
          end
        end
      end
    end

    // R4 overflow drop
    dirRx = 1'b1;
    wrCfg(16'h1F00);
    for (int k = 0; k < 32; k++) pushW(16'h4000 + 16'(k));
    pushW(16'hDEAD);
    chk("R4 level capped", level, 32);
    step();
    chk("R4 level held", level, 32);
    for (int k = 0; k < 32; k++) begin
      chk("R4 contents", popData, model[0]);
      popW();
    end
    chk("R4 drained", level, 0);

    // R5 empty pop
    popEn = 1'b1; step(); popEn = 1'b0;
    chk("R5 underrun pulse", popUnderrun, 1);
    chk("R5 level", level, 0);
    step();
    chk("R5 pulse ends", popUnderrun, 0);
    pushData = 16'h1234; pushEn = 1'b1; popEn = 1'b1; step();
    pushEn = 1'b0; popEn = 1'b0;
    model.push_back(16'h1234);
    chk("R5 push kept", level, 1);
    chk("R5 underrun with push", popUnderrun, 1);
    chk("R5 data", popData, 16'h1234);

    // R6 simultaneous push and pop
    pushW(16'h5678);
    pushData = 16'h9ABC; pushEn = 1'b1; popEn = 1'b1; step();
    pushEn = 1'b0; popEn = 1'b0;
    void'(model.pop_front()); model.push_back(16'h9ABC);
    chk("R6 level", level, 2);
    chk("R6 underrun", popUnderrun, 0);
    for (int k = 0; k < 2; k++) begin
      chk("R6 order", popData, model[0]);
      popW();
    end
    chk("R6 drained", level, 0);

    // R11 config write re-evaluates, R10 idle clear
    dirRx = 1'b0;
    step(); step();
    chk("R8 empty ae0", svcNow(), 4'b0000);
    wrCfg(16'h1F05);
    chk("R11 not yet", svcNow(), 4'b0000);
    step();
    chk("R11 re-evaluated", svcNow(), 4'b0001);
    xferActive = 1'b0;
    step(); step();
    chk("R10 idle empty", svcNow(), 4'b0000);
    pushW(16'h0001);
    step();
    chk("R10 idle not empty", svcNow(), 4'b0001);
    popW();
    xferActive = 1'b1;
    wrCfg(16'h1F85);
    step();
    chk("R8 tx dma", svcNow(), 4'b0010);
    wrCfg(16'h1F00);
    step();
    chk("R11 cleared", svcNow(), 4'b0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule